// File: doc/BRIEF.md
# Double-Data-Rate Two-Word Burst SRAM Port

This block models the synchronous port of a static RAM that moves data on both phases of its clock. It takes a true clock and its complement and uses only the rising edge of each. Every command names one location, and each location holds a pair of words. A write brings in that pair over one clock cycle, one word on each edge. A read returns the pair the same way, with word 0 first and word 1 second.

Commands are taken only on rising edges of the true clock, and only while the load strobe is high. A mode input selects the read latency. In the long setting the first word appears two and a half cycles after the command. In the short setting it appears one cycle after the command. A valid flag frames each returned pair. While the flag is low the read bus is held at zero, which stands for a released shared bus. Two echo clocks run in step with the launch edges, so that a receiver can capture the returned words.

Top module: `ddr2w_sram_port`

## Requirements
- R1: While reset is low and after it is released, rd_valid is 0, rd_data is 0 and echo_clk is 0 until the first true-clock edge. A read that is pending when reset arrives never appears on the outputs.
- R2: A true-clock rising edge with cmd_valid low is a no-operation. No location changes, whatever cmd_write, cmd_addr and wr_data hold.
- R3: A write (cmd_write=1) captured at true-clock edge T takes word 0 from wr_data at the complementary-clock edge T+0.5 and word 1 at the true-clock edge T+1. Both words are stored at cmd_addr.
- R4: With lat_long=1, a read captured at edge T shows word 0 from complementary edge T+2.5 and word 1 from true edge T+3.
- R5: With lat_long=0, a read captured at edge T shows word 0 from true edge T+1 and word 1 from complementary edge T+1.5.
- R6: A read issued in the cycle right after a write to the same location returns the newly written pair. A write issued right after a read of that location does not alter the pair the read returns.
- R7: rd_valid is 1 exactly during the two half-cycles in which a burst's words are driven. While rd_valid is 0, rd_data is 0.
- R8: Out of reset, echo_clk is 1 after every true-clock rising edge and 0 after every complementary-clock rising edge. echo_clk_n is always its inverse.
- R9: Reads issued on consecutive cycles produce an unbroken stream of words, with rd_valid held high across the bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| k | input | 1 | True clock; rising edge captures commands and write word 1 |
| k_n | input | 1 | Complementary clock; rising edge captures write word 0 |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Load strobe; a command is taken only when high |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Location of the two-word pair |
| wr_data | input | DATA_W | Write word bus, sampled on both clock phases |
| lat_long | input | 1 | 1 = two-and-a-half-cycle read latency, 0 = one-cycle |
| rd_data | output | DATA_W | Returned word, zero while no burst is driven |
| rd_valid | output | 1 | High while rd_data carries a read word |
| echo_clk | output | 1 | Echo clock aligned to the launch edges |
| echo_clk_n | output | 1 | Inverse of echo_clk |

## Verification
The assertions assume that lat_long does not change while a read is still in the pipeline. Under that assumption a short-mode launch and a long-mode launch never compete for the same edge. They also assume that k_n is the exact inverse of k. The bench creates k_n by inverting k. It changes the latency mode only after idle cycles have drained every pending burst. It drives every input one nanosecond after an edge, so each value is stable well before the next rising edge of either clock.

// File: rtl/ddr2w_pkg.sv
`timescale 1ns/1ps
package ddr2w_pkg;
   localparam int BURST_LEN = 2;

   typedef enum logic {
      OP_READ  = 1'b0,
      OP_WRITE = 1'b1
   } op_e;
endpackage

// File: rtl/ddr2w_store.sv
`timescale 1ns/1ps
module ddr2w_store
   import ddr2w_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               we,
   input  logic [ADDR_W-1:0]                  waddr,
   input  logic [BURST_LEN-1:0][DATA_W-1:0]   wword,
   input  logic [ADDR_W-1:0]                  raddr,
   output logic [BURST_LEN-1:0][DATA_W-1:0]   rword
);
   localparam int DEPTH = 1 << ADDR_W;

   generate
      if (DEPTH > 4096) begin : g_too_deep
         $error("ddr2w_store: depth exceeds model limit");
      end
      for (genvar g = 0; g < BURST_LEN; g++) begin : g_lane
         logic [DATA_W-1:0] cells [DEPTH];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int a = 0; a < DEPTH; a++) cells[a] <= '0;
            end else if (we) begin
               cells[waddr] <= wword[g];
            end
         end

         assign rword[g] = cells[raddr];
      end
   endgenerate
endmodule

// File: rtl/ddr2w_cmd.sv
`timescale 1ns/1ps
module ddr2w_cmd
   import ddr2w_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8
) (
   input  logic                               k,
   input  logic                               k_n,
   input  logic                               rst_n,
   input  logic                               cmd_valid,
   input  logic                               cmd_write,
   input  logic [ADDR_W-1:0]                  cmd_addr,
   input  logic [DATA_W-1:0]                  wr_data,
   input  logic                               lat_long,
   output logic                               rd_go,
   output logic                               rd_long,
   output logic [ADDR_W-1:0]                  loc_addr,
   output logic                               we,
   output logic [BURST_LEN-1:0][DATA_W-1:0]   wword
);
   logic              s1_rd, s1_wr;
   logic [DATA_W-1:0] wbuf0;
   logic              wbuf_ok;

   // command stage: true-clock edge only
   always_ff @(posedge k or negedge rst_n) begin
      if (!rst_n) begin
         s1_rd    <= 1'b0;
         s1_wr    <= 1'b0;
         rd_long  <= 1'b0;
         loc_addr <= '0;
      end else begin
         s1_rd   <= cmd_valid && (op_e'(cmd_write) == OP_READ);
         s1_wr   <= cmd_valid && (op_e'(cmd_write) == OP_WRITE);
         rd_long <= lat_long;
         if (cmd_valid) loc_addr <= cmd_addr;
      end
   end

   // first write word arrives on the complementary edge
   always_ff @(posedge k_n or negedge rst_n) begin
      if (!rst_n) begin
         wbuf0   <= '0;
         wbuf_ok <= 1'b0;
      end else begin
         wbuf_ok <= s1_wr;
         if (s1_wr) wbuf0 <= wr_data;
      end
   end

   // second word is taken straight off the bus at the committing edge
   assign rd_go = s1_rd;
   assign we    = s1_wr;
   assign wword = {wr_data, wbuf0};

   assert_word0_held_R3: assert property (@(posedge k) disable iff (!rst_n)
      s1_wr |-> wbuf_ok);
endmodule

// File: rtl/ddr2w_rdpipe.sv
`timescale 1ns/1ps
module ddr2w_rdpipe
   import ddr2w_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic                               k,
   input  logic                               k_n,
   input  logic                               rst_n,
   input  logic                               rd_go,
   input  logic                               rd_long,
   input  logic [BURST_LEN-1:0][DATA_W-1:0]   rword,
   output logic [DATA_W-1:0]                  q_k,
   output logic                               v_k,
   output logic [DATA_W-1:0]                  q_kn,
   output logic                               v_kn
);
   logic                             s2_v, s2_long, s3_v;
   logic [BURST_LEN-1:0][DATA_W-1:0] s2_w, s3_w;
   logic                             short_head, short_tail;

   assign short_head = rd_go && !rd_long;
   assign short_tail = s2_v && !s2_long;

   always_ff @(posedge k or negedge rst_n) begin
      if (!rst_n) begin
         s2_v    <= 1'b0;
         s2_long <= 1'b0;
         s2_w    <= '0;
         s3_v    <= 1'b0;
         s3_w    <= '0;
         v_k     <= 1'b0;
         q_k     <= '0;
      end else begin
         s2_v    <= rd_go;
         s2_long <= rd_long;
         s2_w    <= rword;
         s3_v    <= s2_v && s2_long;
         s3_w    <= s2_w;
         v_k     <= short_head || s3_v;
         if (short_head)  q_k <= rword[0];
         else if (s3_v)   q_k <= s3_w[1];
         else             q_k <= '0;
      end
   end

   always_ff @(posedge k_n or negedge rst_n) begin
      if (!rst_n) begin
         v_kn <= 1'b0;
         q_kn <= '0;
      end else begin
         v_kn <= short_tail || s3_v;
         if (short_tail)  q_kn <= s2_w[1];
         else if (s3_v)   q_kn <= s3_w[0];
         else             q_kn <= '0;
      end
   end

   assert_single_launch_k_R9: assert property (@(posedge k) disable iff (!rst_n)
      !(short_head && s3_v));
   assert_single_launch_kn_R9: assert property (@(posedge k_n) disable iff (!rst_n)
      !(short_tail && s3_v));
   assert_long_pipe_R4: assert property (@(posedge k) disable iff (!rst_n)
      (rd_go && rd_long) |=> s2_v ##1 s3_v);
endmodule

// File: rtl/ddr2w_sram_port.sv
`timescale 1ns/1ps
module ddr2w_sram_port
   import ddr2w_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8
) (
   input  logic              k,
   input  logic              k_n,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic              cmd_write,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              lat_long,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              echo_clk,
   output logic              echo_clk_n
);
   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("ddr2w_sram_port: widths must be positive");
      end
      if (BURST_LEN != 2) begin : g_bad_burst
         $error("ddr2w_sram_port: burst length must be two");
      end
   endgenerate

   logic                             rd_go, rd_long, we;
   logic [ADDR_W-1:0]                loc_addr;
   logic [BURST_LEN-1:0][DATA_W-1:0] wword, rword;
   logic [DATA_W-1:0]                q_k, q_kn;
   logic                             v_k, v_kn;
   logic                             tog_k, tog_kn;

   ddr2w_cmd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmd (
      .k(k), .k_n(k_n), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_addr(cmd_addr),
      .wr_data(wr_data), .lat_long(lat_long),
      .rd_go(rd_go), .rd_long(rd_long), .loc_addr(loc_addr),
      .we(we), .wword(wword)
   );

   ddr2w_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
      .clk(k), .rst_n(rst_n), .we(we), .waddr(loc_addr),
      .wword(wword), .raddr(loc_addr), .rword(rword)
   );

   ddr2w_rdpipe #(.DATA_W(DATA_W)) u_pipe (
      .k(k), .k_n(k_n), .rst_n(rst_n),
      .rd_go(rd_go), .rd_long(rd_long), .rword(rword),
      .q_k(q_k), .v_k(v_k), .q_kn(q_kn), .v_kn(v_kn)
   );

   // echo clock: toggle on the true edge, follow on the complementary edge
   always_ff @(posedge k or negedge rst_n) begin
      if (!rst_n) tog_k <= 1'b0;
      else        tog_k <= ~tog_k;
   end

   always_ff @(posedge k_n or negedge rst_n) begin
      if (!rst_n) tog_kn <= 1'b0;
      else        tog_kn <= tog_k;
   end

   assign echo_clk   = tog_k ^ tog_kn;
   assign echo_clk_n = ~echo_clk;

   // the phase now in force selects which launch register drives the bus
   assign rd_valid = k ? v_k : v_kn;
   assign rd_data  = k ? q_k : q_kn;

   assert_idle_bus_k_R7: assert property (@(posedge k) disable iff (!rst_n)
      !rd_valid |-> (rd_data == '0));
   assert_idle_bus_kn_R7: assert property (@(posedge k_n) disable iff (!rst_n)
      !rd_valid |-> (rd_data == '0));
   assert_echo_phase_R8: assert property (@(posedge k) disable iff (!rst_n)
      tog_k == tog_kn);
endmodule

// File: tb/sim_ddr2w_sram_port.sv
`timescale 1ns/1ps
module sim_ddr2w_sram_port;
   localparam int AW   = 4;
   localparam int DW   = 8;
   localparam int NVEC = 14;
   localparam int NEXP = 128;
   localparam int TAIL = 8;

   // entry: {valid, write, addr[3:0], word0[7:0], word1[7:0]}
   localparam logic [21:0] VEC [NVEC] = '{
      {1'b1, 1'b1, 4'h3, 8'h11, 8'h22},  // write A3
      {1'b1, 1'b0, 4'h3, 8'h00, 8'h00},  // R6: read straight after write
      {1'b1, 1'b1, 4'h5, 8'h33, 8'h44},
      {1'b1, 1'b1, 4'h6, 8'h55, 8'h66},
      {1'b1, 1'b0, 4'h5, 8'h00, 8'h00},  // R9: back-to-back reads
      {1'b1, 1'b0, 4'h6, 8'h00, 8'h00},
      {1'b0, 1'b1, 4'h5, 8'hEE, 8'hFF},  // R2: strobe low, no write
      {1'b1, 1'b0, 4'h5, 8'h00, 8'h00},  // R2: expects 33/44
      {1'b1, 1'b0, 4'h3, 8'h00, 8'h00},
      {1'b1, 1'b1, 4'h3, 8'h77, 8'h88},  // R6: write after read, read keeps old
      {1'b1, 1'b0, 4'h3, 8'h00, 8'h00},  // R3: new pair stored
      {1'b0, 1'b0, 4'h0, 8'h00, 8'h00},
      {1'b1, 1'b0, 4'h9, 8'h00, 8'h00},  // never written location
      {1'b0, 1'b0, 4'h0, 8'h00, 8'h00}
   };

   logic          k = 1'b0;
   logic          k_n;
   logic          rst_n;
   logic          cmd_valid, cmd_write, lat_long;
   logic [AW-1:0] cmd_addr;
   logic [DW-1:0] wr_data;
   logic [DW-1:0] rd_data;
   logic          rd_valid, echo_clk, echo_clk_n;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [DW-1:0] ref0 [1<<AW];
   logic [DW-1:0] ref1 [1<<AW];
   logic          exp_v [NEXP];
   logic [DW-1:0] exp_d [NEXP];

   assign k_n = ~k;
   always #5 k = ~k;

   ddr2w_sram_port #(.ADDR_W(AW), .DATA_W(DW)) u0 (
      .k(k), .k_n(k_n), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_addr(cmd_addr),
      .wr_data(wr_data), .lat_long(lat_long),
      .rd_data(rd_data), .rd_valid(rd_valid),
      .echo_clk(echo_clk), .echo_clk_n(echo_clk_n)
   );

   task automatic check_idle(input string tag);
      checks++;
      if (rd_valid !== 1'b0 || rd_data !== '0) begin
         fails++;
         $display("FAIL %s idle outputs actual=%b/%h expected=0/00", tag, rd_valid, rd_data);
      end
   endtask

   task automatic check_slot(input int s, input string tag);
      logic e_echo;
      checks++;
      if (rd_valid !== exp_v[s]) begin
         fails++;
         $display("FAIL R7 slot %0d rd_valid actual=%b expected=%b", s, rd_valid, exp_v[s]);
      end
      checks++;
      if (exp_v[s]) begin
         if (rd_data !== exp_d[s]) begin
            fails++;
            $display("FAIL %s slot %0d rd_data actual=%h expected=%h", tag, s, rd_data, exp_d[s]);
         end
      end else if (rd_data !== '0) begin
         fails++;
         $display("FAIL R7 slot %0d idle rd_data actual=%h expected=00", s, rd_data);
      end
      e_echo = (s % 2 == 0);
      checks++;
      if (echo_clk !== e_echo || echo_clk_n !== ~e_echo) begin
         fails++;
         $display("FAIL R8 slot %0d echo actual=%b%b expected=%b%b", s, echo_clk, echo_clk_n, e_echo, ~e_echo);
      end
   endtask

   // walk the vector table once in the given latency mode (R4 long, R5 short)
   task automatic run_table(input logic mode);
      logic [21:0] cap, prev, nxt;
      int          off;
      string       tag;
      tag = mode ? "R4" : "R5";
      off = mode ? 5 : 2;
      for (int s = 0; s < NEXP; s++) begin
         exp_v[s] = 1'b0;
         exp_d[s] = '0;
      end
      lat_long = mode;
      cap  = '0;
      prev = '0;
      for (int i = 0; i < NVEC + TAIL; i++) begin
         @(posedge k);
         // R3: the pair of the previous write lands at this edge
         if (prev[21] && prev[20]) begin
            ref0[prev[19:16]] = prev[15:8];
            ref1[prev[19:16]] = prev[7:0];
         end
         if (cap[21] && !cap[20]) begin
            exp_v[2*i+off]   = 1'b1;
            exp_d[2*i+off]   = ref0[cap[19:16]];
            exp_v[2*i+off+1] = 1'b1;
            exp_d[2*i+off+1] = ref1[cap[19:16]];
         end
         nxt = (i < NVEC) ? VEC[i] : 22'd0;
         #1;
         cmd_valid = nxt[21];
         cmd_write = nxt[20];
         cmd_addr  = nxt[19:16];
         wr_data   = cap[15:8];
         #1;
         check_slot(2*i, tag);
         @(posedge k_n);
         #1;
         wr_data = cap[7:0];
         #1;
         check_slot(2*i+1, tag);
         prev = cap;
         cap  = nxt;
      end
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      rst_n     = 1'b0;
      cmd_valid = 1'b0;
      cmd_write = 1'b0;
      cmd_addr  = '0;
      wr_data   = '0;
      lat_long  = 1'b1;
      for (int a = 0; a < (1 << AW); a++) begin
         ref0[a] = '0;
         ref1[a] = '0;
      end
      // R1: outputs quiet while in reset
      repeat (3) @(posedge k);
      #2;
      check_idle("R1");
      checks++;
      if (echo_clk !== 1'b0) begin
         fails++;
         $display("FAIL R1 echo_clk in reset actual=%b expected=0", echo_clk);
      end
      #1 rst_n = 1'b1;

      run_table(1'b1);
      run_table(1'b0);

      // R1: a read pending when reset arrives never reaches the outputs
      lat_long = 1'b1;
      @(posedge k);
      #1;
      cmd_valid = 1'b1;
      cmd_write = 1'b0;
      cmd_addr  = 4'h5;
      @(posedge k);
      #1;
      cmd_valid = 1'b0;
      #2 rst_n = 1'b0;
      #1 check_idle("R1");
      @(posedge k);
      #3 rst_n = 1'b1;
      for (int h = 0; h < 8; h++) begin
         @(k);
         #2 check_idle("R1");
      end

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule